// File: doc/BRIEF.md
# Chained DMA Descriptor Loader

This block runs one DMA channel that works through a linked list of transfer control blocks (descriptors) in internal memory. Software writes a pointer to the first descriptor. The channel then reads the four descriptor words over a read port that allows one outstanding request. It loads its start address, step and word count registers from those words. It then hands out one data-word address per accepted beat to the peripheral data path. When the count runs out, it follows the next-descriptor pointer that it fetched with the block.

Every pointer addresses the highest word of its descriptor, and the descriptor is read from there downward. Stored addresses are offsets from an internal memory base of 0x80000. The channel adds the base before it drives either bus. The top bit of a pointer is an interrupt-mode flag and is never part of an address. It selects whether an interrupt is raised after the block that pointer fetches, or only when the whole list has finished. The interrupt stays set until software clears it. The current pointer, address and count are visible on status outputs.

Top module: `chain_dma_ctrl`

## Requirements
- R1: While the channel is idle and `chain_en` is 1, a `cp_wr` pulse whose `cp_wdata[18:0]` is nonzero loads `cur_ptr` and raises `active`. On the very next clock `rd_req_valid` is 1 with `rd_req_addr` = 0x80000 + `cp_wdata[18:0]`. A write is ignored, leaving `cur_ptr` and the read port unchanged, when `chain_en` is 0, when bits 18:0 are zero, or when the channel is already active.
- R2: With pointer field F, the four descriptor reads go to 0x80000+F, F-1, F-2 and F-3, in that order. They load the start address (response bits 18:0), the step (bits 18:0), the word count (bits 15:0) and the next pointer (bits 19:0) respectively.
- R3: A read request holds its address stable until `rd_req_ready` is seen. The next request is issued only after `rd_rsp_valid` has returned the previous word.
- R4: After loading, `xfer_valid` is 1 while the count is nonzero, with `xfer_addr` = 0x80000 + `cur_index`. Each accepted beat adds the step to `cur_index` modulo 2^19 and decrements `cur_count` by one.
- R5: A descriptor whose word count is zero produces no data beats. The channel moves straight on to the next descriptor or to the end of the list.
- R6: When a block finishes and the next pointer it fetched has bits 18:0 equal to zero, the channel goes idle and sets `irq`.
- R7: When a block finishes and the next pointer is nonzero, `irq` is set only if bit 19 of the pointer that fetched this block was 1. The next descriptor fetch starts in either case.
- R8: `irq` stays 1 until a cycle with `irq_clr` high clears it. A new set in the same cycle as a clear wins.
- R9: After reset, `cur_ptr`, `cur_index` and `cur_count` are 0, and `irq`, `active`, `rd_req_valid` and `xfer_valid` are 0.
- R10: After a list ends, `cur_ptr` holds the last pointer word fetched. Each following descriptor is read from the address field of the pointer fetched with the previous block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chain_en | input | 1 | Channel allowed to start a chained run |
| cp_wr | input | 1 | Pointer write strobe |
| cp_wdata | input | 20 | Pointer value: bit 19 interrupt-mode flag, bits 18:0 address offset |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 24 | Descriptor word bus address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 32 | Read data word |
| xfer_valid | output | 1 | Data-word address offered |
| xfer_ready | input | 1 | Data path takes the word |
| xfer_addr | output | 24 | Data-word bus address |
| irq | output | 1 | Latched channel interrupt |
| irq_clr | input | 1 | Write-one-to-clear pulse for `irq` |
| active | output | 1 | Channel fetching or transferring |
| cur_ptr | output | 20 | Current chain pointer register |
| cur_index | output | 19 | Current data address offset |
| cur_count | output | 16 | Remaining word count |

## Verification
A directed three-descriptor list mixes a unit step, an empty block and a negative step that wraps below zero. This separates correct modulo address stepping and count-zero skipping from off-by-one or sign errors. It also includes a pointer write made while busy, which must not disturb the run. Seeded random lists of one to four descriptors with random flags, counts, steps and handshake stalls expose any wrong read order, a lost word under back-pressure, or an interrupt raised for the wrong block. An interrupt-mode case compares per-block flags against end-only lists. A final run holds the interrupt uncleared to show that it latches. Writes with chaining disabled or with a zero address field must leave the pointer and read port untouched.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

  // Channel sequencing
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_FETCH = 2'd1,
    CH_XFER  = 2'd2
  } ch_state_t;

  // Descriptor read sequencing
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_state_t;

  // Order in which descriptor words arrive (read downward from the pointer)
  localparam logic [1:0] SLOT_INDEX = 2'd0;
  localparam logic [1:0] SLOT_STEP  = 2'd1;
  localparam logic [1:0] SLOT_COUNT = 2'd2;
  localparam logic [1:0] SLOT_CHAIN = 2'd3;
  localparam int unsigned DESC_WORDS = 4;

endpackage

// File: rtl/cdma_desc_fetch.sv
module cdma_desc_fetch
  import cdma_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned FIELD_W = 19,
  parameter logic [ADDR_W-1:0] MEM_BASE = 24'h080000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FIELD_W-1:0] start_field,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_req_addr,
  input  logic               rd_rsp_valid,
  input  logic [DATA_W-1:0]  rd_rsp_data,
  output logic               ld_valid,
  output logic [1:0]         ld_slot,
  output logic [DATA_W-1:0]  ld_data,
  output logic               done
);

  localparam logic [1:0] LAST_SLOT = 2'(DESC_WORDS - 1);

  fetch_state_t       st_q, st_d;
  logic [1:0]         step_q, step_d;
  logic [FIELD_W-1:0] field_q, field_d;
  logic               field_en;

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    field_d  = field_q;
    field_en = 1'b0;
    ld_valid = 1'b0;
    done     = 1'b0;
    case (st_q)
      FS_IDLE: begin
        if (start) begin
          field_d  = start_field;
          field_en = 1'b1;
          step_d   = 2'd0;
          st_d     = FS_REQ;
        end
      end
      FS_REQ: begin
        if (rd_req_ready) st_d = FS_WAIT;
      end
      FS_WAIT: begin
        if (rd_rsp_valid) begin
          ld_valid = 1'b1;
          if (step_q == LAST_SLOT) begin
            done = 1'b1;
            st_d = FS_IDLE;
          end else begin
            step_d = step_q + 2'd1;
            st_d   = FS_REQ;
          end
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FS_IDLE;
      step_q  <= 2'd0;
      field_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      if (field_en) field_q <= field_d;
    end
  end

  assign rd_req_valid = (st_q == FS_REQ);
  assign rd_req_addr  = MEM_BASE + ADDR_W'(field_q - FIELD_W'(step_q));
  assign ld_slot      = step_q;
  assign ld_data      = rd_rsp_data;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> !rd_req_valid);

endmodule

// File: rtl/cdma_param_regs.sv
module cdma_param_regs
  import cdma_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned FIELD_W = 19,
  parameter int unsigned CNT_W   = 16,
  parameter logic [ADDR_W-1:0] MEM_BASE = 24'h080000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  input  logic [1:0]         ld_slot,
  input  logic [DATA_W-1:0]  ld_data,
  input  logic               run,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [ADDR_W-1:0]  xfer_addr,
  output logic [FIELD_W-1:0] cur_index,
  output logic [CNT_W-1:0]   cur_count,
  output logic               cnt_zero
);

  logic [FIELD_W-1:0] idx_q, idx_d, step_q, step_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               idx_en, step_en, cnt_en;
  logic               beat;
  logic               unused_ld_hi;

  assign unused_ld_hi = ^ld_data[DATA_W-1:FIELD_W];

  assign cnt_zero   = (cnt_q == '0);
  assign xfer_valid = run && !cnt_zero;
  assign beat       = xfer_valid && xfer_ready;

  // Next-state logic: descriptor loads and per-beat update
  always_comb begin
    idx_d   = idx_q;
    step_d  = step_q;
    cnt_d   = cnt_q;
    idx_en  = 1'b0;
    step_en = 1'b0;
    cnt_en  = 1'b0;
    if (ld_valid) begin
      case (ld_slot)
        SLOT_INDEX: begin idx_d  = ld_data[FIELD_W-1:0]; idx_en  = 1'b1; end
        SLOT_STEP:  begin step_d = ld_data[FIELD_W-1:0]; step_en = 1'b1; end
        SLOT_COUNT: begin cnt_d  = ld_data[CNT_W-1:0];   cnt_en  = 1'b1; end
        default: ;
      endcase
    end else if (beat) begin
      idx_d  = idx_q + step_q;
      cnt_d  = cnt_q - 1'b1;
      idx_en = 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      step_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (idx_en)  idx_q  <= idx_d;
      if (step_en) step_q <= step_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  assign xfer_addr = MEM_BASE + ADDR_W'(idx_q);
  assign cur_index = idx_q;
  assign cur_count = cnt_q;

  // R4
  beat_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready |=> (cur_count == $past(cur_count) - 1'b1) &&
                                 (cur_index == $past(cur_index) + $past(step_q)));

  // R2
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && (ld_slot == SLOT_COUNT) |=> cur_count == $past(ld_data[CNT_W-1:0]));

endmodule

// File: rtl/cdma_irq_latch.sv
module cdma_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);

  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (clr) irq_d = 1'b0;
    if (set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr |=> irq);

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> !irq);

  // R8
  irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> irq);

endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import cdma_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned PTR_W  = 20,
  parameter int unsigned CNT_W  = 16,
  parameter logic [ADDR_W-1:0] MEM_BASE = 24'h080000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_en,
  input  logic              cp_wr,
  input  logic [PTR_W-1:0]  cp_wdata,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              irq,
  input  logic              irq_clr,
  output logic              active,
  output logic [PTR_W-1:0]  cur_ptr,
  output logic [PTR_W-2:0]  cur_index,
  output logic [CNT_W-1:0]  cur_count
);

  localparam int unsigned FIELD_W  = PTR_W - 1;
  localparam int unsigned FLAG_BIT = PTR_W - 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ch_state_t          st_q, st_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               ptr_en;
  logic               pci_q, pci_d;
  logic               pci_en;
  logic               start_ok, blk_end, next_zero;
  logic               fetch_start, fetch_done;
  logic [FIELD_W-1:0] fetch_field;
  logic               ld_valid;
  logic [1:0]         ld_slot;
  logic [DATA_W-1:0]  ld_data;
  logic               cnt_zero, irq_set;
  logic               unused_ld_hi;

  assign unused_ld_hi = ^ld_data[DATA_W-1:PTR_W];

  assign start_ok    = (st_q == CH_IDLE) && cp_wr && chain_en &&
                       (cp_wdata[FIELD_W-1:0] != '0);
  assign blk_end     = (st_q == CH_XFER) && cnt_zero;
  assign next_zero   = (ptr_q[FIELD_W-1:0] == '0);
  assign fetch_start = start_ok || (blk_end && !next_zero);
  assign fetch_field = start_ok ? cp_wdata[FIELD_W-1:0] : ptr_q[FIELD_W-1:0];
  assign irq_set     = blk_end && (next_zero || pci_q);

  // Channel next-state logic
  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    pci_d  = pci_q;
    pci_en = 1'b0;
    case (st_q)
      CH_IDLE: begin
        if (start_ok) begin
          st_d   = CH_FETCH;
          ptr_d  = cp_wdata;
          ptr_en = 1'b1;
          pci_d  = cp_wdata[FLAG_BIT];
          pci_en = 1'b1;
        end
      end
      CH_FETCH: begin
        if (ld_valid && (ld_slot == SLOT_CHAIN)) begin
          ptr_d  = ld_data[PTR_W-1:0];
          ptr_en = 1'b1;
        end
        if (fetch_done) st_d = CH_XFER;
      end
      CH_XFER: begin
        if (blk_end) begin
          if (next_zero) begin
            st_d = CH_IDLE;
          end else begin
            st_d   = CH_FETCH;
            pci_d  = ptr_q[FLAG_BIT];
            pci_en = 1'b1;
          end
        end
      end
      default: st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q  <= CH_IDLE;
      ptr_q <= '0;
      pci_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ptr_en) ptr_q <= ptr_d;
      if (pci_en) pci_q <= pci_d;
    end
  end

  assign active  = (st_q != CH_IDLE);
  assign cur_ptr = ptr_q;

  cdma_desc_fetch #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .MEM_BASE(MEM_BASE)
  ) u_fetch (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start        (fetch_start),
    .start_field  (fetch_field),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .ld_valid     (ld_valid),
    .ld_slot      (ld_slot),
    .ld_data      (ld_data),
    .done         (fetch_done)
  );

  cdma_param_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W),
    .MEM_BASE(MEM_BASE)
  ) u_params (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ld_valid   (ld_valid),
    .ld_slot    (ld_slot),
    .ld_data    (ld_data),
    .run        (st_q == CH_XFER),
    .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready),
    .xfer_addr  (xfer_addr),
    .cur_index  (cur_index),
    .cur_count  (cur_count),
    .cnt_zero   (cnt_zero)
  );

  cdma_irq_latch u_irq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set   (irq_set),
    .clr   (irq_clr),
    .irq   (irq)
  );

  // R1
  start_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_ok |=> rd_req_valid && (rd_req_addr == MEM_BASE + ADDR_W'($past(cp_wdata[FIELD_W-1:0]))));

  // R1
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    active && cp_wr && !(ld_valid && (ld_slot == SLOT_CHAIN)) |=> $stable(cur_ptr));

  // R3
  req_when_active_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_req_valid |-> active && !xfer_valid);

  // R6
  chain_end_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    blk_end && next_zero |=> !active && irq);

endmodule

// File: tb/tb_chain_dma_ctrl.sv
module tb_chain_dma_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 24;
  localparam int PTR_W  = 20;
  localparam int CNT_W  = 16;
  localparam logic [ADDR_W-1:0] BASE = 24'h080000;

  logic              clk, rst_n;
  logic              chain_en, cp_wr;
  logic [PTR_W-1:0]  cp_wdata;
  logic              rd_req_valid, rd_req_ready;
  logic [ADDR_W-1:0] rd_req_addr;
  logic              rd_rsp_valid;
  logic [DATA_W-1:0] rd_rsp_data;
  logic              xfer_valid, xfer_ready;
  logic [ADDR_W-1:0] xfer_addr;
  logic              irq, irq_clr, active;
  logic [PTR_W-1:0]  cur_ptr;
  logic [PTR_W-2:0]  cur_index;
  logic [CNT_W-1:0]  cur_count;

  chain_dma_ctrl dut (
    .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .cp_wr(cp_wr), .cp_wdata(cp_wdata),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .irq(irq), .irq_clr(irq_clr), .active(active),
    .cur_ptr(cur_ptr), .cur_index(cur_index), .cur_count(cur_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests, fails;
  bit finished;

  logic [31:0]       mem [0:1023];
  logic [ADDR_W-1:0] exp_rd [0:63];
  logic [ADDR_W-1:0] got_rd [0:63];
  logic [ADDR_W-1:0] exp_x  [0:63];
  logic [ADDR_W-1:0] got_x  [0:63];
  int exp_rd_n, got_rd_n, exp_x_n, got_x_n, exp_irq, irq_seen;
  logic [PTR_W-1:0]  exp_last_ptr;
  logic [PTR_W-2:0]  exp_last_idx;

  bit auto_clr, man_clr, rsp_pend;
  int rsp_dly;
  logic [ADDR_W-1:0] rsp_addr;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench-side memory and data-path responder, sampled away from the rising edge
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
      xfer_ready = 1'b0; irq_clr = 1'b0; rsp_pend = 1'b0; rsp_dly = 0;
    end else begin
      rd_rsp_valid = 1'b0;
      if (rsp_pend) begin
        if (rsp_dly == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = mem[int'(rsp_addr - BASE)];
          rsp_pend     = 1'b0;
        end else rsp_dly--;
      end
      rd_req_ready = ($urandom % 3) != 0;
      if (rd_req_valid && rd_req_ready) begin
        if (got_rd_n < 64) got_rd[got_rd_n] = rd_req_addr;
        got_rd_n++;
        rsp_pend = 1'b1;
        rsp_dly  = $urandom % 3;
        rsp_addr = rd_req_addr;
      end
      xfer_ready = ($urandom % 4) != 0;
      if (xfer_valid && xfer_ready) begin
        if (got_x_n < 64) got_x[got_x_n] = xfer_addr;
        got_x_n++;
      end
      if (auto_clr) begin
        if (irq && !irq_clr) begin irq_seen++; irq_clr = 1'b1; end
        else irq_clr = 1'b0;
      end else irq_clr = man_clr;
    end
  end

  // Independent model of the list walk
  task automatic walk(input logic [PTR_W-1:0] p);
    logic [PTR_W-1:0] q;
    logic [18:0] f, idx, st;
    logic [15:0] cn;
    logic [PTR_W-1:0] nx;
    q = p; exp_rd_n = 0; exp_x_n = 0; exp_irq = 0;
    for (int b = 0; b < 8; b++) begin
      f = q[18:0];
      for (int s = 0; s < 4; s++) begin
        exp_rd[exp_rd_n] = BASE + ADDR_W'(f - 19'(s));
        exp_rd_n++;
      end
      idx = mem[int'(f)][18:0];
      st  = mem[int'(f) - 1][18:0];
      cn  = mem[int'(f) - 2][15:0];
      nx  = mem[int'(f) - 3][19:0];
      for (int k = 0; k < int'(cn); k++) begin
        exp_x[exp_x_n] = BASE + ADDR_W'(idx);
        exp_x_n++;
        idx = idx + st;
      end
      exp_last_ptr = nx;
      exp_last_idx = idx;
      if (nx[18:0] == '0) begin exp_irq++; break; end
      if (q[19]) exp_irq++;
      q = nx;
    end
  endtask

  task automatic put_desc(input int base, input logic [18:0] idx, input logic [18:0] st,
                          input logic [15:0] cn, input logic [19:0] nx);
    mem[base + 3] = {13'd0, idx};
    mem[base + 2] = {13'd0, st};
    mem[base + 1] = {16'd0, cn};
    mem[base]     = {12'd0, nx};
  endtask

  task automatic run_chain(input logic [PTR_W-1:0] p, input bit poke, input string tag);
    @(posedge clk);
    got_rd_n = 0; got_x_n = 0; irq_seen = 0;
    walk(p);
    @(negedge clk); cp_wr = 1'b1; cp_wdata = p;
    @(negedge clk); cp_wr = 1'b0;
    check({tag, " R1 first read valid"}, 32'(rd_req_valid), 32'd1);
    check({tag, " R1 first read addr"}, 32'(rd_req_addr), 32'(BASE + ADDR_W'(p[18:0])));
    if (poke) begin
      repeat (3) @(negedge clk);
      cp_wr = 1'b1; cp_wdata = 20'h00053;
      @(negedge clk); cp_wr = 1'b0;
    end
    while (active) @(negedge clk);
    repeat (3) @(negedge clk);
    check({tag, " R2 read count"}, 32'(got_rd_n), 32'(exp_rd_n));
    for (int i = 0; i < exp_rd_n && i < got_rd_n; i++)
      check({tag, " R2 R10 read order"}, 32'(got_rd[i]), 32'(exp_rd[i]));
    check({tag, " R4 R5 beat count"}, 32'(got_x_n), 32'(exp_x_n));
    for (int i = 0; i < exp_x_n && i < got_x_n; i++)
      check({tag, " R4 beat addr"}, 32'(got_x[i]), 32'(exp_x[i]));
    check({tag, " R4 final index"}, 32'(cur_index), 32'(exp_last_idx));
    check({tag, " R4 final count"}, 32'(cur_count), 32'd0);
    if (auto_clr) check({tag, " R6 R7 irq events"}, 32'(irq_seen), 32'(exp_irq));
    check({tag, " R10 final pointer"}, 32'(cur_ptr), 32'(exp_last_ptr));
    check({tag, " R6 idle"}, 32'(active), 32'd0);
  endtask

  initial begin
    int seed_disc;
    logic [19:0] start_p;
    int nb;
    tests = 0; fails = 0; finished = 1'b0;
    seed_disc = $urandom(32'd7741);
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    rst_n = 1'b0; chain_en = 1'b0; cp_wr = 1'b0; cp_wdata = '0;
    auto_clr = 1'b1; man_clr = 1'b0;
    got_rd_n = 0; got_x_n = 0; irq_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check("R9 cur_ptr", 32'(cur_ptr), 32'd0);
    check("R9 cur_index", 32'(cur_index), 32'd0);
    check("R9 cur_count", 32'(cur_count), 32'd0);
    check("R9 irq/active/req/xfer", {28'd0, irq, active, rd_req_valid, xfer_valid}, 32'd0);

    // R1 ignored writes: chaining off, then zero address field
    put_desc(16'h10, 19'h100, 19'd1, 16'd3, 20'h80023);
    cp_wr = 1'b1; cp_wdata = 20'h00013;
    @(negedge clk); cp_wr = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 disabled write ptr", 32'(cur_ptr), 32'd0);
    check("R1 disabled write reads", 32'(got_rd_n), 32'd0);
    chain_en = 1'b1;
    cp_wr = 1'b1; cp_wdata = 20'h80000;
    @(negedge clk); cp_wr = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 zero-field write ptr", 32'(cur_ptr), 32'd0);
    check("R1 zero-field write active", {31'd0, active}, 32'd0);

    // Directed list: unit step, empty block with flag, wrapping negative step
    put_desc(16'h20, 19'h200, 19'd2, 16'd0, 20'h00033);
    put_desc(16'h30, 19'd2, 19'h7FFFF, 16'd4, 20'h00000);
    run_chain(20'h00013, 1'b1, "directed");

    // Random lists
    for (int r = 0; r < 10; r++) begin
      nb = 1 + ($urandom % 4);
      for (int b = 0; b < nb; b++) begin
        logic [19:0] nx;
        logic [18:0] st;
        nx = (b == nb - 1) ? {($urandom % 2) == 1, 19'd0}
                           : {($urandom % 2) == 1, 19'(16'h40 + 16 * (b + 1) + 3)};
        st = (($urandom % 2) == 1) ? 19'($urandom) : 19'($urandom % 5);
        put_desc(16'h40 + 16 * b, 19'($urandom), st, 16'($urandom % 7), nx);
      end
      start_p = {($urandom % 2) == 1, 19'h43};
      run_chain(start_p, 1'b0, "random");
    end

    // R8: latch holds without a clear, then clears
    auto_clr = 1'b0;
    put_desc(16'h10, 19'h50, 19'd1, 16'd1, 20'h00000);
    run_chain(20'h00013, 1'b0, "hold");
    check("R8 irq latched", {31'd0, irq}, 32'd1);
    repeat (20) @(negedge clk);
    check("R8 irq held", {31'd0, irq}, 32'd1);
    man_clr = 1'b1;
    @(negedge clk); man_clr = 1'b0;
    @(negedge clk);
    check("R8 irq cleared", {31'd0, irq}, 32'd0);

    // R7: end-only mode raises exactly one event for a two-block list
    auto_clr = 1'b1;
    repeat (2) @(negedge clk);
    put_desc(16'h10, 19'h60, 19'd1, 16'd2, 20'h00023);
    put_desc(16'h20, 19'h70, 19'd1, 16'd2, 20'h00000);
    run_chain(20'h00013, 1'b0, "endonly");
    check("R7 single end event", 32'(irq_seen), 32'd1);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule